// File: doc/BRIEF.md
# External Interrupt Sense and Pending Latch

This block turns a set of external interrupt request pins and a group of on-chip request lines into per-source pending bits, and drives a vector of masked requests to a downstream priority arbiter. Every request is active low. Each external pin can be programmed for one of two senses. In level mode the pending bit follows the pin. In falling-edge mode a high-to-low transition is captured and held until software acknowledges it. The on-chip lines are always level-sensed, active low. There is no rising-edge mode and no active-high mode.

Software uses a small register port with four word addresses. The sense word selects the mode of each external pin. The pending word shows the pending bits and takes acknowledge writes. The mask word enables sources. The force word injects requests from software. In the pending, mask and force words, source b is at bit position 31-b, so source 0 is the most significant bit. External pins are synchronised with two flops before any sensing.

Top module: `xirq_sense_latch`

## Requirements
- R1: After reset every register is zero. All sources are masked, all pins are in level mode, and `irq_o` and every readback are zero.
- R2: The sense word is at address 0. External pin 0 is at bit 15 and pin n is at bit 15-n. A 1 selects falling-edge sensing and a 0 selects low-level sensing. All other bits read as 0.
- R3: For a level-sensed external pin, the pending bit goes high on the third rising clock edge after the pin goes low and clears on the third edge after it returns high. Writing 1 to its pending bit does not clear it while the pin is still low.
- R4: For an edge-sensed pin, a high-to-low transition sets the pending bit on the third edge. The bit stays set after the pin returns high, and it does not set again while the pin is simply held low.
- R5: The pending word is at address 1. Writing a 1 to a bit clears a latched edge event on the same edge as the write. Writing a 0 has no effect.
- R6: Sources 8 and above are on-chip lines. Each one sets its pending bit on the first edge after it goes low and clears it on the first edge after it goes high. The sense word never affects them.
- R7: In the pending, mask and force words, source b occupies bit 31-b.
- R8: The force word is at address 3. While a force bit is 1, the matching pending bit is 1 from the second edge after the write, whatever the pin does.
- R9: The mask word is at address 2, and a 1 enables a source. `irq_o[b]` equals pending AND mask for source b, and it follows a mask write on the edge of that write.
- R10: A read returns the word at `reg_addr`, registered one edge later.
- R11: In edge mode a low-to-high transition does not set the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n | input | NUM_EXT | Asynchronous external requests, active low |
| int_irq_n | input | NUM_INT | On-chip level requests, active low, synchronous |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Word address: 0 sense, 1 pending, 2 mask, 3 force |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_EXT+NUM_INT | Masked pending requests, bit b is source b |

## Verification
Each result is due a fixed number of edges after its stimulus:
- An external pin change shows at `irq_o` on the third edge: two synchroniser flops, then the pending register.
- An on-chip line shows on the first edge.
- A force write shows on the second edge.
- A mask write or an acknowledge shows on the edge of the write.
- A readback is one edge behind the state it reports.

The bench drives inputs at falling clock edges and samples at falling edges. For external pins it first checks that `irq_o` has not yet changed one edge early, then checks that it has changed at the exact edge. The bench sweeps every external pin in both modes and every on-chip source, and it computes the expected bit positions as 31-b and 15-n.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int REG_W     = 32;
  localparam int SENSE_TOP = 15;
  localparam int ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SENSE = 2'd0,
    ADDR_PEND  = 2'd1,
    ADDR_MASK  = 2'd2,
    ADDR_FORCE = 2'd3
  } xirq_addr_e;
endpackage

// File: rtl/xirq_pin_sync.sv
module xirq_pin_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_n,
  output logic [WIDTH-1:0] cur_n,
  output logic [WIDTH-1:0] fall
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= pin_n[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign cur_n[i] = s2_q;
    assign fall[i]  = s3_q & ~s2_q;
  end
endmodule

// File: rtl/xirq_src_cell.sv
module xirq_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic edge_mode,
  input  logic req_n,
  input  logic fall,
  input  logic ack,
  input  logic force_i,
  output logic pend_o
);
  logic lat_q, pend_q, lat_nxt;

  assign lat_nxt = edge_mode & ((lat_q & ~ack) | fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lat_q  <= lat_nxt;
      pend_q <= (edge_mode ? lat_nxt : ~req_n) | force_i;
    end
  end

  assign pend_o = pend_q;

  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!edge_mode && !req_n) |=> pend_q);
  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && lat_q && !ack) |=> lat_q);
  // R4
  edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && fall) |=> pend_q);
  // R8
  force_set_chk: assert property (@(posedge clk) disable iff (rst)
    force_i |=> pend_q);
endmodule

// File: rtl/xirq_sense_latch.sv
module xirq_sense_latch
  import xirq_pkg::*;
#(
  parameter int NUM_EXT = 8,
  parameter int NUM_INT = 8,
  localparam int N_SRC  = NUM_EXT + NUM_INT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] ext_irq_n,
  input  logic [NUM_INT-1:0] int_irq_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [N_SRC-1:0]   irq_o
);
  logic [NUM_EXT-1:0] sense_q;
  logic [N_SRC-1:0]   mask_q, force_q, pend, ack;
  logic [NUM_EXT-1:0] cur_n, fall;
  logic [REG_W-1:0]   sense_word, pend_word, mask_word, force_word, rdata_q;

  xirq_pin_sync #(.WIDTH(NUM_EXT)) u_sync (
    .clk(clk), .rst(rst), .pin_n(ext_irq_n), .cur_n(cur_n), .fall(fall)
  );

  for (genvar b = 0; b < N_SRC; b++) begin : g_src
    assign ack[b] = reg_wr && (reg_addr == ADDR_PEND) && reg_wdata[REG_W-1-b];
    if (b < NUM_EXT) begin : g_ext
      xirq_src_cell u_cell (
        .clk(clk), .rst(rst), .edge_mode(sense_q[b]), .req_n(cur_n[b]),
        .fall(fall[b]), .ack(ack[b]), .force_i(force_q[b]), .pend_o(pend[b])
      );
    end else begin : g_int
      xirq_src_cell u_cell (
        .clk(clk), .rst(rst), .edge_mode(1'b0), .req_n(int_irq_n[b-NUM_EXT]),
        .fall(1'b0), .ack(ack[b]), .force_i(force_q[b]), .pend_o(pend[b])
      );
    end
  end

  always_comb begin
    sense_word = '0;
    pend_word  = '0;
    mask_word  = '0;
    force_word = '0;
    for (int n = 0; n < NUM_EXT; n++) sense_word[SENSE_TOP-n] = sense_q[n];
    for (int b = 0; b < N_SRC; b++) begin
      pend_word[REG_W-1-b]  = pend[b];
      mask_word[REG_W-1-b]  = mask_q[b];
      force_word[REG_W-1-b] = force_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_q <= '0;
      mask_q  <= '0;
      force_q <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_wr) begin
        case (xirq_addr_e'(reg_addr))
          ADDR_SENSE: for (int n = 0; n < NUM_EXT; n++) sense_q[n] <= reg_wdata[SENSE_TOP-n];
          ADDR_MASK:  for (int b = 0; b < N_SRC; b++) mask_q[b] <= reg_wdata[REG_W-1-b];
          ADDR_FORCE: for (int b = 0; b < N_SRC; b++) force_q[b] <= reg_wdata[REG_W-1-b];
          default: ;
        endcase
      end
      case (xirq_addr_e'(reg_addr))
        ADDR_SENSE: rdata_q <= sense_word;
        ADDR_PEND:  rdata_q <= pend_word;
        ADDR_MASK:  rdata_q <= mask_word;
        default:    rdata_q <= force_word;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = pend & mask_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pend == '0 && mask_q == '0 && force_q == '0 && sense_q == '0));
endmodule

// File: tb/sim_xirq_sense_latch.sv
module sim_xirq_sense_latch;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int NI = 8;
  localparam int NS = NE + NI;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NE-1:0] ext_irq_n = '1;
  logic [NI-1:0] int_irq_n = '1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NS-1:0] irq_o;
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xirq_sense_latch #(.NUM_EXT(NE), .NUM_INT(NI)) u0 (
    .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .int_irq_n(int_irq_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    step(1);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] sbit(input int b);
    return 32'h1 << (31 - b);
  endfunction

  function automatic logic [31:0] vbit(input int b);
    return 32'h1 << b;
  endfunction

  initial begin
    logic [31:0] d;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 readback", d, 0);
    end
    // R2 only the sense bits for pins 0..7 (bits 15..8) exist
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    chk("R2 sense width", d, 32'h0000_FF00);
    wr(2'd0, 32'h0);
    // R9 unmask everything
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d);
    chk("R7 mask word", d, 32'hFFFF_0000);

    for (int n = 0; n < NE; n++) begin
      // R3 level mode
      ext_irq_n[n] = 1'b0;
      step(2);
      chk("R3 not yet", 32'(irq_o), 0);
      step(1);
      chk("R3 level set", 32'(irq_o), vbit(n));
      rd(2'd1, d);
      chk("R7 pend pos", d, sbit(n));
      wr(2'd1, sbit(n));
      step(1);
      chk("R3 ack ignored", 32'(irq_o), vbit(n));
      ext_irq_n[n] = 1'b1;
      step(2);
      chk("R3 still set", 32'(irq_o), vbit(n));
      step(1);
      chk("R3 level clear", 32'(irq_o), 0);
      // R2 edge mode for this pin only
      wr(2'd0, 32'h1 << (15 - n));
      rd(2'd0, d);
      chk("R2 sense pos", d, 32'h1 << (15 - n));
      ext_irq_n[n] = 1'b0;
      step(2);
      chk("R4 not yet", 32'(irq_o), 0);
      step(1);
      chk("R4 edge set", 32'(irq_o), vbit(n));
      wr(2'd1, sbit(n));
      chk("R5 ack clears", 32'(irq_o), 0);
      step(3);
      chk("R4 held low no retrigger", 32'(irq_o), 0);
      ext_irq_n[n] = 1'b1;
      step(4);
      chk("R11 rising ignored", 32'(irq_o), 0);
      ext_irq_n[n] = 1'b0;
      step(3);
      ext_irq_n[n] = 1'b1;
      step(4);
      chk("R4 latched after release", 32'(irq_o), vbit(n));
      wr(2'd1, 32'h0);
      step(1);
      chk("R5 write zero", 32'(irq_o), vbit(n));
      wr(2'd1, ~sbit(n));
      chk("R5 other bits", 32'(irq_o), vbit(n));
      wr(2'd1, sbit(n));
      chk("R5 ack", 32'(irq_o), 0);
      wr(2'd0, 32'h0);
    end

    // R6 on-chip sources, sense word set to all edge
    wr(2'd0, 32'hFFFF_FFFF);
    for (int i = 0; i < NI; i++) begin
      int_irq_n[i] = 1'b0;
      step(1);
      chk("R6 int set", 32'(irq_o), vbit(NE + i));
      rd(2'd1, d);
      chk("R7 int pend pos", d, sbit(NE + i));
      int_irq_n[i] = 1'b1;
      step(1);
      chk("R6 int clear", 32'(irq_o), 0);
    end
    wr(2'd0, 32'h0);

    // R8 force on every source
    for (int b = 0; b < NS; b++) begin
      wr(2'd3, sbit(b));
      chk("R8 not yet", 32'(irq_o), 0);
      step(1);
      chk("R8 force", 32'(irq_o), vbit(b));
      wr(2'd3, 32'h0);
      step(1);
      chk("R8 release", 32'(irq_o), 0);
    end

    // R9 mask gates the output, pending still visible
    wr(2'd3, sbit(3) | sbit(12));
    step(1);
    wr(2'd2, sbit(12));
    chk("R9 masked", 32'(irq_o), vbit(12));
    rd(2'd1, d);
    chk("R9 pend unmasked", d, sbit(3) | sbit(12));
    rd(2'd3, d);
    chk("R10 force readback", d, sbit(3) | sbit(12));
    wr(2'd2, 32'h0);
    chk("R9 all masked", 32'(irq_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule